// File: doc/BRIEF.md
# Bus Hold Arbitration Controller

This block decides who owns a 16-bit local bus: the local master or an external requester that asks for the bus with a hold request. A logical transfer from the local master may take one to three 16-bit bus cycles. Wide or misaligned accesses are split into locked sequences. The block tracks each transfer from its start strobe to the last ready-terminated cycle. It grants the bus only once the whole sequence has finished, however many wait states each cycle takes. No external lock indication is produced for these split sequences.

While the grant is active, the block withdraws its output enable. The pad drivers for address, data, byte enables, the address strobe, the lock pin and the cycle-definition pins then float. While the bus is given away, a new transfer request from the local master is held off. A non-maskable interrupt edge that arrives at any time, including during the hold, is stored. It is only presented to the interrupt logic while the bus is owned locally. At most one edge is kept.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset, hlda is 0, bus_oe is 1 and nmi_pending is 0.
- R2: xfer_ack is high in any cycle where xfer_start is high, no transfer is active, hlda is low and the synchronized hold is low. The accepted transfer then lasts xfer_cycles bus cycles. A value of 0 counts as 1, and a value above 3 counts as 3. Each cycle ends on a clock edge where ready is high.
- R3: hold passes through two flops. When it is raised with the bus idle, hlda rises on the third rising clock edge.
- R4: hlda never rises while a transfer is in progress. For a transfer of N cycles with W wait states each, with hold raised before the accepting edge, hlda rises exactly N*(W+1)+1 edges after the accepting edge.
- R5: bus_oe is low exactly while hlda is high.
- R6: When hold is lowered, hlda falls on the third rising clock edge.
- R7: While hlda is high, or while the synchronized hold is high, xfer_ack stays low. A waiting request is acknowledged in the first cycle after hlda falls.
- R8: A rising edge on nmi is stored three clock edges after it arrives. It shows on nmi_pending only while hlda is low, so an edge seen during hold appears once hlda falls.
- R9: Only one edge is stored. Further edges while one is stored are dropped. A cycle with nmi_ack high while nmi_pending is high clears the store at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Local master requests a new logical transfer |
| xfer_cycles | input | 2 | Number of 16-bit cycles in the requested transfer |
| ready | input | 1 | Ends the current bus cycle when high at a clock edge |
| hold | input | 1 | Asynchronous bus request from the external master |
| nmi | input | 1 | Asynchronous non-maskable interrupt line |
| nmi_ack | input | 1 | Interrupt logic has taken the pending NMI |
| xfer_ack | output | 1 | The transfer request is accepted this cycle |
| hlda | output | 1 | Bus granted to the external master |
| bus_oe | output | 1 | Enable for the bus pin drivers, low while floated |
| nmi_pending | output | 1 | A stored NMI edge is ready for service |

## Verification
xfer_ack is combinational and is sampled one time unit after the inputs change. Every registered result is sampled two time units after the rising edge that produces it. For the grant, the bench counts edges from the accepting edge and expects hlda to be high from edge N*(W+1)+1 onward. It sweeps every cycle count from 0 to 3 against zero to three wait states. The release and idle-grant checks sample on the second edge (still the old value) and the third edge (new value) after hold changes. The NMI store is checked in the same way, on the second edge and the third edge after the rising edge.

// File: rtl/bha_pkg.sv
`timescale 1ns/1ps
package bha_pkg;
   typedef enum logic {
      XF_IDLE   = 1'b0,
      XF_ACTIVE = 1'b1
   } xfer_state_e;
endpackage

// File: rtl/bha_sync.sv
`timescale 1ns/1ps
module bha_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 1) begin : g_bad_stages
      $error("bha_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk) begin
         if (!rst_n) q_r <= RESET_VAL;
         else        q_r <= d_in;
      end
      assign q_out = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] chain_r;
      always_ff @(posedge clk) begin
         if (!rst_n) chain_r <= {STAGES{RESET_VAL}};
         else        chain_r <= {chain_r[STAGES-2:0], d_in};
      end
      assign q_out = chain_r[STAGES-1];
   end
endmodule

// File: rtl/bha_xfer_tracker.sv
`timescale 1ns/1ps
module bha_xfer_tracker
   import bha_pkg::*;
#(
   parameter int MAX_CYCLES = 3,
   localparam int CNT_W = $clog2(MAX_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [CNT_W-1:0] cycles_in,
   input  logic             ready,
   output logic             busy
);
   xfer_state_e      state_r;
   logic [CNT_W-1:0] remain_r;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      if (cycles_in == '0)
         load_val = CNT_W'(1);
      else if (cycles_in > CNT_W'(MAX_CYCLES))
         load_val = CNT_W'(MAX_CYCLES);
      else
         load_val = cycles_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_r  <= XF_IDLE;
         remain_r <= '0;
      end else begin
         case (state_r)
            XF_IDLE: begin
               if (accept) begin
                  remain_r <= load_val;
                  state_r  <= XF_ACTIVE;
               end
            end
            XF_ACTIVE: begin
               if (ready) begin
                  remain_r <= remain_r - CNT_W'(1);
                  if (remain_r == CNT_W'(1)) state_r <= XF_IDLE;
               end
            end
            default: state_r <= XF_IDLE;
         endcase
      end
   end

   assign busy = (state_r == XF_ACTIVE);
endmodule

// File: rtl/bha_hold_ctrl.sv
`timescale 1ns/1ps
module bha_hold_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_s,
   input  logic busy,
   output logic hlda
);
   logic grant_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_r <= 1'b0;
      end else if (grant_r) begin
         if (!hold_s) grant_r <= 1'b0;
      end else if (hold_s && !busy) begin
         grant_r <= 1'b1;
      end
   end

   assign hlda = grant_r;
endmodule

// File: rtl/bha_nmi_latch.sv
`timescale 1ns/1ps
module bha_nmi_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_s,
   input  logic hlda,
   input  logic nmi_ack,
   output logic nmi_pending
);
   logic prev_r;
   logic stored_r;
   logic rise;

   assign rise = nmi_s && !prev_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_r   <= 1'b0;
         stored_r <= 1'b0;
      end else begin
         prev_r <= nmi_s;
         if (rise)
            stored_r <= 1'b1;
         else if (nmi_ack && !hlda)
            stored_r <= 1'b0;
      end
   end

   assign nmi_pending = stored_r && !hlda;
endmodule

// File: rtl/bus_hold_arbiter.sv
`timescale 1ns/1ps
module bus_hold_arbiter #(
   parameter int MAX_CYCLES  = 3,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W = $clog2(MAX_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_start,
   input  logic [CNT_W-1:0] xfer_cycles,
   input  logic             ready,
   input  logic             hold,
   input  logic             nmi,
   input  logic             nmi_ack,
   output logic             xfer_ack,
   output logic             hlda,
   output logic             bus_oe,
   output logic             nmi_pending
);
   if (MAX_CYCLES < 1) begin : g_bad_cycles
      $error("bus_hold_arbiter: MAX_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("bus_hold_arbiter: SYNC_STAGES must be at least 1");
   end

   logic hold_sync;
   logic nmi_sync;
   logic xfer_busy;
   logic grant;

   bha_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_hold_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (hold),
      .q_out (hold_sync)
   );

   bha_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_nmi_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (nmi),
      .q_out (nmi_sync)
   );

   assign xfer_ack = xfer_start && !xfer_busy && !grant && !hold_sync;

   bha_xfer_tracker #(.MAX_CYCLES(MAX_CYCLES)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (xfer_ack),
      .cycles_in (xfer_cycles),
      .ready     (ready),
      .busy      (xfer_busy)
   );

   bha_hold_ctrl u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_s (hold_sync),
      .busy   (xfer_busy),
      .hlda   (grant)
   );

   bha_nmi_latch u_nmi (
      .clk         (clk),
      .rst_n       (rst_n),
      .nmi_s       (nmi_sync),
      .hlda        (grant),
      .nmi_ack     (nmi_ack),
      .nmi_pending (nmi_pending)
   );

   assign hlda   = grant;
   assign bus_oe = !grant;
endmodule

// File: rtl/bha_checker.sv
`timescale 1ns/1ps
module bha_checker (
   input logic clk,
   input logic rst_n,
   input logic hlda,
   input logic bus_oe,
   input logic xfer_ack,
   input logic nmi_pending,
   input logic nmi_ack,
   input logic busy,
   input logic hold_s
);
   p_grant_after_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda) |-> !$past(busy));

   p_grant_needs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda) |-> $past(hold_s));

   p_float_on_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda) |-> !bus_oe);

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hlda && !hold_s) |=> !hlda);

   p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> !xfer_ack);

   p_nmi_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pending && !nmi_ack && !hold_s) |=> nmi_pending);
endmodule

bind bus_hold_arbiter bha_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hlda        (hlda),
   .bus_oe      (bus_oe),
   .xfer_ack    (xfer_ack),
   .nmi_pending (nmi_pending),
   .nmi_ack     (nmi_ack),
   .busy        (xfer_busy),
   .hold_s      (hold_sync)
);

// File: tb/sim_bus_hold_arbiter.sv
`timescale 1ns/1ps
module sim_bus_hold_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_start = 1'b0;
   logic [1:0] xfer_cycles = 2'd0;
   logic       ready = 1'b0;
   logic       hold = 1'b0;
   logic       nmi = 1'b0;
   logic       nmi_ack = 1'b0;
   logic       xfer_ack, hlda, bus_oe, nmi_pending;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   bus_hold_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_cycles(xfer_cycles),
      .ready(ready), .hold(hold), .nmi(nmi), .nmi_ack(nmi_ack),
      .xfer_ack(xfer_ack), .hlda(hlda), .bus_oe(bus_oe), .nmi_pending(nmi_pending)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 hlda", hlda, 1'b0);
      chk("R1 bus_oe", bus_oe, 1'b1);
      chk("R1 nmi_pending", nmi_pending, 1'b0);

      // R2, R4, R5, R6: sweep cycle counts and wait states
      for (int c = 0; c < 4; c++) begin
         for (int w = 0; w < 4; w++) begin
            int n;
            int t;
            n = (c == 0) ? 1 : c;
            t = n * (w + 1);
            xfer_start  = 1'b1;
            xfer_cycles = 2'(c);
            hold        = 1'b1;
            ready       = 1'b0;
            #1;
            chk("R2 ack", xfer_ack, 1'b1);
            tick();
            xfer_start = 1'b0;
            for (int k = 1; k <= t + 2; k++) begin
               ready = (((k - 1) % (w + 1)) == w);
               tick();
               chk("R4 grant timing", hlda, (k >= t + 1));
               chk("R5 bus_oe", bus_oe, !(k >= t + 1));
            end
            ready = 1'b0;
            hold  = 1'b0;
            tick(); chk("R6 hold edge1", hlda, 1'b1);
            tick(); chk("R6 hold edge2", hlda, 1'b1);
            tick(); chk("R6 released", hlda, 1'b0);
            chk("R5 bus_oe back", bus_oe, 1'b1);
            tick();
         end
      end

      // R3: grant on an idle bus
      hold = 1'b1;
      tick(); chk("R3 edge1", hlda, 1'b0);
      tick(); chk("R3 edge2", hlda, 1'b0);
      tick(); chk("R3 edge3", hlda, 1'b1);

      // R7 stall and R8 NMI during hold, R9 second edge dropped
      xfer_start  = 1'b1;
      xfer_cycles = 2'd1;
      #1;
      chk("R7 stalled", xfer_ack, 1'b0);
      nmi = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R7 stalled loop", xfer_ack, 1'b0);
         chk("R8 masked in hold", nmi_pending, 1'b0);
      end
      nmi = 1'b0;
      tick(); tick(); tick();
      nmi = 1'b1;
      tick(); tick(); tick(); tick();
      nmi = 1'b0;
      chk("R8 masked in hold 2", nmi_pending, 1'b0);
      hold = 1'b0;
      tick(); chk("R7 hold edge1", xfer_ack, 1'b0);
      tick(); chk("R7 hold edge2", xfer_ack, 1'b0);
      tick();
      #1;
      chk("R7 accepted after release", xfer_ack, 1'b1);
      chk("R8 presented after release", nmi_pending, 1'b1);
      ready = 1'b1;
      tick();
      xfer_start = 1'b0;
      tick();
      ready   = 1'b0;
      nmi_ack = 1'b1;
      tick();
      nmi_ack = 1'b0;
      chk("R9 cleared by ack", nmi_pending, 1'b0);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R9 single edge kept", nmi_pending, 1'b0);
      end

      // R8 edge timing outside hold
      nmi = 1'b1;
      tick(); chk("R8 edge1", nmi_pending, 1'b0);
      tick(); chk("R8 edge2", nmi_pending, 1'b0);
      tick(); chk("R8 edge3", nmi_pending, 1'b1);
      nmi = 1'b0;
      nmi_ack = 1'b1;
      tick();
      nmi_ack = 1'b0;
      chk("R9 ack clears", nmi_pending, 1'b0);

      // R7 tie: synchronized hold high on an idle bus blocks a request
      hold = 1'b1;
      tick(); tick();
      xfer_start = 1'b1;
      #1;
      chk("R7 hold wins tie", xfer_ack, 1'b0);
      tick();
      chk("R3 granted on tie", hlda, 1'b1);
      xfer_start = 1'b0;
      hold = 1'b0;
      tick(); tick(); tick();
      chk("R6 final release", hlda, 1'b0);

      finish_run();
   end
endmodule